// File: doc/BRIEF.md
# Response-Keyed Layered Unlock Sequencer

The block sits in front of a protected design and keeps it locked after power-up. Unlocking needs a sequence of added transition steps. Each step is driven by a device-unique response word and a license word supplied from outside. Steps alternate between two kinds:

- **Branching steps** pick one of several branch states from the next group of response bits.
- **Checking steps** accept the transition only when a license group XOR the matching response group equals the passkey stored for the branch just taken.

A wrong check sends the machine into a trap state that no later input can leave. After every step succeeds, the machine enters the protected design's reset state and raises `unlocked`.

The passkeys are a parameter table. Changing them reconfigures the lock, so that a license computed for an older table no longer opens it. The response word arrives as a plain input with a valid strobe. Producing that response and computing the license are handled elsewhere.

Top module: `puf_layer_lock`

## Requirements
- R1: After synchronous reset, `unlocked` and `fail` are 0, `layer` is 0, and the latched response and license words are zero.
- R2: A start pulse taken while idle latches both words. `layer` then rises by one at each following clock edge. The response word holds NUM_STEPS groups of GROUP_W bits, and group 0 is the most significant.
- R3: On each branching step (step index 2j), the branch index becomes the value of response group 2j. On the checking step 2j+1 that follows, the machine advances only if license group j (most significant first) XOR response group 2j+1 equals the passkey for check j and that branch. That passkey is PASSKEYS[(j*2^GROUP_W + branch)*GROUP_W +: GROUP_W].
- R4: A failed check makes `fail` 1 at the clock edge of that step. `layer` freezes at the index of the failing step, and the machine stays in this state until reset.
- R5: When all NUM_STEPS steps succeed, `unlocked` becomes 1 with `layer` equal to NUM_STEPS, NUM_STEPS edges after the start edge. The latched response word is zero from that cycle on.
- R6: A start pulse has no effect in each of these cases:
  - `resp_valid` is low;
  - the walk is already under way;
  - the machine is trapped;
  - the machine is unlocked.
  Input words that change after the start edge are also ignored.
- R7: Case with 4 branches and 2 steps: response 0100 unlocks with license 10 when the passkey is 10. Licenses 00, 01 and 11 trap with `layer` equal to 1.
- R8: Case with 4 steps: response 10101010 and passkeys 01 then 11. License 1110 traps at step 3 because the second check yields 00, not 11. License 1101 unlocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the unlock walk |
| resp_valid | input | 1 | Response word is valid |
| resp_word | input | NUM_STEPS*GROUP_W | Device response, group 0 in the most significant bits |
| lic_word | input | NUM_STEPS/2*GROUP_W | License, group 0 in the most significant bits |
| unlocked | output | 1 | Protected design released |
| fail | output | 1 | Machine is trapped |
| layer | output | $clog2(NUM_STEPS+1) | Count of steps completed |

## Verification
A wrong branch register or a mis-sliced group does not show up right away. It appears at the next checking step, one or two edges later, as `fail` rising with `layer` frozen at an odd index when an unlock was expected, or the reverse. A state register that leaves the trap or the unlocked state shows at the next edge after a start pulse. A skipped or repeated step shifts the cycle in which `unlocked` rises away from NUM_STEPS edges after the start edge. The bench therefore samples both the intermediate layer and the final outcome at fixed cycle offsets.

// File: rtl/plock_pkg.sv
package plock_pkg;

   typedef enum logic [1:0] {
      PL_IDLE = 2'd0,
      PL_WALK = 2'd1,
      PL_OPEN = 2'd2,
      PL_TRAP = 2'd3
   } plock_state_e;

endpackage

// File: rtl/plock_group_pick.sv
// Selects one GW-bit group from a packed word; group 0 is the most significant.
module plock_group_pick #(
   parameter int GW     = 2,
   parameter int GROUPS = 4,
   parameter int IDX_W  = 3
) (
   input  logic [GW*GROUPS-1:0] word,
   input  logic [IDX_W-1:0]     idx,
   output logic [GW-1:0]        group_o
);

   logic [GW-1:0] grp [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_slice
      assign grp[g] = word[(GROUPS-1-g)*GW +: GW];
   end

   always_comb begin
      group_o = '0;
      for (int i = 0; i < GROUPS; i++) begin
         if (idx == IDX_W'(i)) group_o = grp[i];
      end
   end

endmodule

// File: rtl/plock_key_table.sv
// Passkey lookup by check index and branch index, built from a parameter table.
module plock_key_table #(
   parameter int GW     = 2,
   parameter int CHECKS = 2,
   parameter int IDX_W  = 3,
   parameter logic [CHECKS*(2**GW)*GW-1:0] KEYS = '0
) (
   input  logic [IDX_W-1:0] chk,
   input  logic [GW-1:0]    branch,
   output logic [GW-1:0]    key
);

   localparam int BR = 2 ** GW;

   logic [GW-1:0] entry [CHECKS][BR];

   for (genvar c = 0; c < CHECKS; c++) begin : g_chk
      for (genvar b = 0; b < BR; b++) begin : g_br
         assign entry[c][b] = KEYS[(c*BR+b)*GW +: GW];
      end
   end

   always_comb begin
      key = '0;
      for (int c = 0; c < CHECKS; c++) begin
         for (int b = 0; b < BR; b++) begin
            if (chk == IDX_W'(c) && branch == GW'(b)) key = entry[c][b];
         end
      end
   end

endmodule

// File: rtl/plock_sequencer.sv
// Layered walk: even steps branch on response, odd steps verify license.
module plock_sequencer
   import plock_pkg::*;
#(
   parameter int NUM_STEPS = 4,
   parameter int GW        = 2,
   parameter int STEP_W    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_ok,
   input  logic [GW-1:0]     resp_grp,
   input  logic [GW-1:0]     lic_grp,
   input  logic [GW-1:0]     passkey,
   output plock_state_e      state_q,
   output logic [STEP_W-1:0] step_q,
   output logic [GW-1:0]     branch_q,
   output logic              capture,
   output logic              wipe
);

   localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

   plock_state_e      state_d;
   logic [STEP_W-1:0] step_d;
   logic [GW-1:0]     branch_d;

   always_comb begin
      state_d  = state_q;
      step_d   = step_q;
      branch_d = branch_q;
      capture  = 1'b0;
      wipe     = 1'b0;
      unique case (state_q)
         PL_IDLE: begin
            if (start_ok) begin
               state_d = PL_WALK;
               step_d  = '0;
               capture = 1'b1;
            end
         end
         PL_WALK: begin
            if (!step_q[0]) begin
               branch_d = resp_grp;
               step_d   = step_q + 1'b1;
            end else if ((lic_grp ^ resp_grp) == passkey) begin
               step_d = step_q + 1'b1;
               if (step_q == LAST) begin
                  state_d = PL_OPEN;
                  wipe    = 1'b1;
               end
            end else begin
               state_d = PL_TRAP;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= PL_IDLE;
         step_q   <= '0;
         branch_q <= '0;
      end else begin
         state_q  <= state_d;
         step_q   <= step_d;
         branch_q <= branch_d;
      end
   end

endmodule

// File: rtl/puf_layer_lock.sv
module puf_layer_lock
   import plock_pkg::*;
#(
   parameter int NUM_STEPS = 4,
   parameter int GROUP_W   = 2,
   parameter logic [NUM_STEPS/2*(2**GROUP_W)*GROUP_W-1:0] PASSKEYS = 16'h729C
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 start,
   input  logic                                 resp_valid,
   input  logic [NUM_STEPS*GROUP_W-1:0]         resp_word,
   input  logic [NUM_STEPS/2*GROUP_W-1:0]       lic_word,
   output logic                                 unlocked,
   output logic                                 fail,
   output logic [$clog2(NUM_STEPS+1)-1:0]       layer
);

   localparam int CHECKS = NUM_STEPS / 2;
   localparam int RESP_W = NUM_STEPS * GROUP_W;
   localparam int LIC_W  = CHECKS * GROUP_W;
   localparam int STEP_W = $clog2(NUM_STEPS + 1);

   if (NUM_STEPS < 2 || (NUM_STEPS % 2) != 0) begin : g_bad_steps
      $error("NUM_STEPS must be even and at least 2");
   end
   if (GROUP_W < 1 || GROUP_W > 4) begin : g_bad_group
      $error("GROUP_W must lie in 1..4");
   end

   logic [RESP_W-1:0] resp_q;
   logic [LIC_W-1:0]  lic_q;
   plock_state_e      state_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] chk_idx;
   logic [GROUP_W-1:0] branch_q, resp_grp, lic_grp, passkey;
   logic capture, wipe;

   assign chk_idx = step_q >> 1;

   plock_group_pick #(.GW(GROUP_W), .GROUPS(NUM_STEPS), .IDX_W(STEP_W)) u_resp_pick (
      .word(resp_q), .idx(step_q), .group_o(resp_grp)
   );

   plock_group_pick #(.GW(GROUP_W), .GROUPS(CHECKS), .IDX_W(STEP_W)) u_lic_pick (
      .word(lic_q), .idx(chk_idx), .group_o(lic_grp)
   );

   plock_key_table #(.GW(GROUP_W), .CHECKS(CHECKS), .IDX_W(STEP_W), .KEYS(PASSKEYS)) u_keys (
      .chk(chk_idx), .branch(branch_q), .key(passkey)
   );

   plock_sequencer #(.NUM_STEPS(NUM_STEPS), .GW(GROUP_W), .STEP_W(STEP_W)) u_seq (
      .clk(clk), .rst(rst), .start_ok(start & resp_valid),
      .resp_grp(resp_grp), .lic_grp(lic_grp), .passkey(passkey),
      .state_q(state_q), .step_q(step_q), .branch_q(branch_q),
      .capture(capture), .wipe(wipe)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_q <= '0;
         lic_q  <= '0;
      end else if (capture) begin
         resp_q <= resp_word;
         lic_q  <= lic_word;
      end else if (wipe) begin
         resp_q <= '0;
      end
   end

   assign unlocked = (state_q == PL_OPEN);
   assign fail     = (state_q == PL_TRAP);
   assign layer    = step_q;

endmodule

// File: rtl/plock_checker.sv
module plock_checker #(
   parameter int STEP_W = 3,
   parameter int RESP_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              unlocked,
   input logic              fail,
   input logic [STEP_W-1:0] layer,
   input logic [RESP_W-1:0] resp_q
);

   assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
      !(unlocked && fail));

   assert_trap_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      fail |=> (fail && $stable(layer)));

   assert_open_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      unlocked |=> (unlocked && $stable(layer)));

   assert_trap_ignores_start_R6: assert property (@(posedge clk) disable iff (rst)
      (fail && start) |=> (fail && !unlocked));

   assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
      (layer != '0 && !unlocked && !fail) |=>
         ((layer == $past(layer) + 1'b1) || (fail && $stable(layer))));

   assert_resp_wiped_R5: assert property (@(posedge clk) disable iff (rst)
      unlocked |-> (resp_q == '0));

endmodule

bind puf_layer_lock plock_checker #(.STEP_W(STEP_W), .RESP_W(RESP_W)) u_plock_chk (
   .clk(clk), .rst(rst), .start(start), .unlocked(unlocked),
   .fail(fail), .layer(layer), .resp_q(resp_q)
);

// File: tb/test_puf_layer_lock.sv
module test_puf_layer_lock;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst = 1'b1;
   logic       start4 = 1'b0, start2 = 1'b0, valid = 1'b1;
   logic [7:0] resp4 = '0;
   logic [3:0] lic4 = '0;
   logic [3:0] resp2 = '0;
   logic [1:0] lic2 = '0;
   logic       unl4, fail4, unl2, fail2;
   logic [2:0] lay4;
   logic [1:0] lay2;

   puf_layer_lock #(.NUM_STEPS(4), .GROUP_W(2), .PASSKEYS(16'h729C)) i_puf_layer_lock (
      .clk(clk), .rst(rst), .start(start4), .resp_valid(valid),
      .resp_word(resp4), .lic_word(lic4),
      .unlocked(unl4), .fail(fail4), .layer(lay4)
   );

   puf_layer_lock #(.NUM_STEPS(2), .GROUP_W(2), .PASSKEYS(8'h39)) i_puf_layer_lock_short (
      .clk(clk), .rst(rst), .start(start2), .resp_valid(valid),
      .resp_word(resp2), .lic_word(lic2),
      .unlocked(unl2), .fail(fail2), .layer(lay2)
   );

   typedef struct {
      int    sel;
      int    due;
      int    unl;
      int    fl;
      int    lay;
      string tag;
   } exp_t;

   exp_t sb[$];
   int cyc = 0, n_cmp = 0, n_bad = 0, launch_cyc = 0;

   task automatic compare(string tag, int sel, int eu, int ef, int el);
      int au, af, al;
      au = (sel == 4) ? int'(unl4)  : int'(unl2);
      af = (sel == 4) ? int'(fail4) : int'(fail2);
      al = (sel == 4) ? int'(lay4)  : int'(lay2);
      n_cmp++;
      if (au != eu || af != ef || al != el) begin
         n_bad++;
         $display("FAIL %s: got unlocked=%0d fail=%0d layer=%0d, expected unlocked=%0d fail=%0d layer=%0d",
                  tag, au, af, al, eu, ef, el);
      end
   endtask

   // monitor: pops scoreboard items when their cycle arrives
   always @(negedge clk) begin
      cyc++;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         compare(sb[0].tag, sb[0].sel, sb[0].unl, sb[0].fl, sb[0].lay);
         void'(sb.pop_front());
      end
   end

   task automatic do_reset();
      @(negedge clk); #1 rst = 1'b1;
      repeat (2) @(negedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic launch(int sel, logic [7:0] resp, logic [3:0] lic, logic v);
      @(negedge clk); #1;
      valid = v;
      if (sel == 4) begin resp4 = resp; lic4 = lic; start4 = 1'b1; end
      else begin resp2 = resp[3:0]; lic2 = lic[1:0]; start2 = 1'b1; end
      launch_cyc = cyc;
      @(negedge clk); #1;
      start4 = 1'b0; start2 = 1'b0; valid = 1'b1;
   endtask

   task automatic expect_at(int sel, int k, int u, int f, int l, string tag);
      exp_t e;
      e.sel = sel; e.due = launch_cyc + k + 1;
      e.unl = u; e.fl = f; e.lay = l; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic drain();
      wait (sb.size() == 0);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      @(negedge clk);
      compare("R1 reset state long", 4, 0, 0, 0);
      compare("R1 reset state short", 2, 0, 0, 0);

      // R7 worked case plus R2 intermediate layer
      launch(2, 8'h04, 4'b0010, 1'b1);
      expect_at(2, 1, 0, 0, 1, "R2 layer after branch step");
      expect_at(2, 2, 1, 0, 2, "R7 worked case unlocks (R5)");
      drain();

      for (int w = 0; w < 4; w++) begin
         if (w == 2) continue;
         do_reset();
         launch(2, 8'h04, 4'(w), 1'b1);
         expect_at(2, 2, 0, 1, 1, "R7 wrong license traps");
         drain();
      end

      // R8 reconfigured passkeys
      do_reset();
      launch(4, 8'hAA, 4'b1110, 1'b1);
      expect_at(4, 2, 0, 0, 2, "R2 layer after first check");
      expect_at(4, 4, 0, 1, 3, "R8 old license traps at step 3");
      drain();
      do_reset();
      launch(4, 8'hAA, 4'b1101, 1'b1);
      expect_at(4, 4, 1, 0, 4, "R8 new license unlocks (R5)");
      drain();

      // R6 start ignored while unlocked
      launch(4, 8'hAA, 4'b0000, 1'b1);
      expect_at(4, 4, 1, 0, 4, "R6 start ignored when unlocked");
      drain();

      // R4 first check fails, then R6 start ignored in trap
      do_reset();
      launch(4, 8'hAA, 4'b0010, 1'b1);
      expect_at(4, 2, 0, 1, 1, "R4 trap at first check");
      expect_at(4, 6, 0, 1, 1, "R4 trap persists");
      drain();
      launch(4, 8'hAA, 4'b1101, 1'b1);
      expect_at(4, 5, 0, 1, 1, "R6 start ignored in trap");
      drain();

      // R3 other branches
      do_reset();
      launch(4, 8'b00_01_11_11, 4'b01_10, 1'b1);
      expect_at(4, 4, 1, 0, 4, "R3 branches 0 and 3 unlock");
      drain();
      do_reset();
      launch(4, 8'b01_00_01_00, 4'b11_00, 1'b1);
      expect_at(4, 4, 1, 0, 4, "R3 branch 1 twice unlocks");
      drain();
      do_reset();
      launch(4, 8'b10_00_01_00, 4'b11_00, 1'b1);
      expect_at(4, 2, 0, 1, 1, "R3 same license on branch 2 traps");
      drain();

      // R6 valid low ignored
      do_reset();
      launch(4, 8'hAA, 4'b1101, 1'b0);
      expect_at(4, 4, 0, 0, 0, "R6 start without valid ignored");
      drain();

      // R6 inputs changed after start edge ignored
      launch(4, 8'hAA, 4'b1101, 1'b1);
      resp4 = 8'h00; lic4 = 4'h0;
      expect_at(4, 4, 1, 0, 4, "R6 late input change ignored");
      drain();

      // R1 reset after unlock
      do_reset();
      @(negedge clk);
      compare("R1 reset clears unlocked", 4, 0, 0, 0);

      finish_run();
   end

endmodule